// File: doc/BRIEF.md
# Processor-to-System-Bus Burst Bridge

This block connects a narrow external processor port to a 32-bit internal system bus that carries one parity bit. The processor side is built for 8, 16 or 32 data bits, with optional odd parity per byte. It accepts single-beat accesses and fixed 16-byte bursts. Each access becomes one or more 32-bit word transfers on the internal side.

On a write, narrow beats are packed little-endian into words. Each completed word waits in a small write queue until the internal bus takes it. On a read, the bridge fetches words from the internal bus into a read queue. It then returns them beat by beat as the processor asks for them. The two queues let either side run ahead of, or stall behind, the other.

A processor access is a strobe held high with its address, direction, burst flag and write data. Each beat is closed by an acknowledge or by an error pulse. An internal word transfer is a request held with a stable address until the slave grants it and signals ready in the same cycle.

Top module: `cpu_sys_bridge`

## Requirements
- R1: A single beat moves PW/8 bytes (PW = 8, 16 or 32). Its bytes sit in the byte lanes of `cpu_addr[1:0]`, rounded down to the beat width. The bridge makes one internal write with `sys_be` bit n set for each lane written, or one internal read whose lane is returned on `cpu_rdata`.
- R2: A burst write has 16/(PW/8) beats. Beat k fills byte address start+k*(PW/8), packed little-endian (lowest address in bits 7:0). It produces exactly four internal writes with `sys_be` = 4'b1111, at start, start+4, start+8 and start+12.
- R3: A burst read makes four internal word reads and returns the 16 bytes in ascending address order, PW/8 bytes per beat.
- R4: A burst whose start address has `cpu_addr[3:0]` other than zero gets `cpu_err` high and `cpu_ack` low for that beat. No internal transfer follows.
- R5: With parity enabled, each `cpu_wpar[n]` must give odd parity over byte n of `cpu_wdata`. On a mismatch, `par_err` rises and stays high until reset, and the word holding the bad beat is never written internally.
- R6: With parity enabled, `cpu_rpar[n]` gives odd parity over byte n of `cpu_rdata` on every read beat.
- R7: `sys_wpar` gives odd parity over the 32 bits of `sys_wdata`. A read word whose `sys_rpar` does not give odd parity over `sys_rdata` sets `par_err`, and the data is still delivered.
- R8: `cpu_ack` stays low on a write while the write queue (FIFO_DEPTH words) is full. It stays low on a read until the needed word has arrived.
- R9: An internal read is never issued while earlier writes are still queued, so a read that follows a write returns the written data.
- R10: After reset, `cpu_ack`, `cpu_err`, `sys_req` and `par_err` are all low.
- R11: An internal transfer completes in a cycle where `sys_req`, `sys_gnt` and `sys_rdy` are all high. Until then, `sys_req` stays high with `sys_addr` and `sys_we` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_stb | input | 1 | Processor beat strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_burst | input | 1 | 1 = 16-byte burst, sampled at the first beat |
| cpu_addr | input | 32 | Byte address; start address for a burst |
| cpu_wdata | input | PW | Write beat data |
| cpu_wpar | input | PW/8 | Odd parity per write byte |
| cpu_ack | output | 1 | Beat accepted / read data valid |
| cpu_err | output | 1 | Beat rejected (misaligned burst) |
| cpu_rdata | output | PW | Read beat data |
| cpu_rpar | output | PW/8 | Odd parity per read byte |
| par_err | output | 1 | Sticky parity error |
| sys_req | output | 1 | Internal transfer request |
| sys_we | output | 1 | Internal transfer is a write |
| sys_addr | output | 32 | Internal word address |
| sys_be | output | 4 | Internal byte enables |
| sys_wdata | output | 32 | Internal write word |
| sys_wpar | output | 1 | Odd parity of sys_wdata |
| sys_gnt | input | 1 | Bus granted to the bridge |
| sys_rdy | input | 1 | Slave ready; transfer completes |
| sys_rdata | input | 32 | Internal read word |
| sys_rpar | input | 1 | Odd parity of sys_rdata |

## Verification
The bench packs two half-word singles into one word and checks the word in its slave memory. A bridge that ignored the lane offset, or wrote all four byte enables, would overwrite the neighbouring half. It stalls the slave until the write queue is full and expects the fifth beat to be held off, then queues a write followed by a read of the same address. A bridge that let the read overtake the write would return stale data. It sends a misaligned burst, a write beat with bad parity and a read word with bad parity. Faulty handling of these would show as a stray internal transfer, a corrupted memory word or a missing sticky flag. Burst transfers are checked for exactly four word transfers at ascending addresses, with the beats returned in order.

// File: rtl/brg_pkg.sv
package brg_pkg;

   typedef struct packed {
      logic [31:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
   } wr_ent_t;

   function automatic logic odd_par8(input logic [7:0] b);
      return ~^b;
   endfunction

endpackage

// File: rtl/brg_fifo.sv
module brg_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("brg_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));
   assign rdata = store[rp];

   always_ff @(posedge clk) begin
      if (push && !full) store[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push && !full)  wp <= wp + 1'b1;
         if (pop && !empty)  rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);  // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);  // R3

endmodule

// File: rtl/brg_cpu_side.sv
module brg_cpu_side
   import brg_pkg::*;
#(
   parameter int PW     = 16,
   parameter bit PAR_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_stb,
   input  logic            cpu_we,
   input  logic            cpu_burst,
   input  logic [31:0]     cpu_addr,
   input  logic [PW-1:0]   cpu_wdata,
   input  logic [PW/8-1:0] cpu_wpar,
   output logic            cpu_ack,
   output logic            cpu_err,
   output logic [PW-1:0]   cpu_rdata,
   output logic [PW/8-1:0] cpu_rpar,
   output logic            par_err,
   input  logic            sys_perr,
   output logic            wf_push,
   output wr_ent_t         wf_wdata,
   input  logic            wf_full,
   output logic            rf_pop,
   input  logic [31:0]     rf_rdata,
   input  logic            rf_empty,
   output logic            rd_start,
   output logic            rd_burst,
   output logic [31:0]     rd_addr
);
   localparam int BYTES = PW / 8;
   localparam int NB    = 16 / BYTES;
   localparam logic [1:0] OFF_MAX = 2'(4 - BYTES);

   logic [3:0]  bc;
   logic        rd_act, rd_burst_q, bad_q, perr_q;
   logic [1:0]  rd_off_q;
   logic [27:0] base_q;
   logic [31:0] wbuf, merged;
   logic [3:0]  lane_be, bpos;
   logic [1:0]  boff;
   logic        start, burst_now, last_lane, word_end, misal, wr_ack, rd_ack, beat_bad;
   logic [27:0] base_hi;

   assign start     = (bc == '0) && !rd_act;
   assign burst_now = rd_act ? rd_burst_q : ((bc != '0) || cpu_burst);
   assign bpos      = bc * 4'(BYTES);
   assign boff      = burst_now ? bpos[1:0]
                    : (rd_act ? rd_off_q : (cpu_addr[1:0] & OFF_MAX));
   assign last_lane = (boff == OFF_MAX);
   assign word_end  = !burst_now || last_lane;
   assign base_hi   = (bc == '0) ? cpu_addr[31:4] : base_q;

   assign misal    = cpu_stb && start && cpu_burst && (cpu_addr[3:0] != 4'h0);
   assign cpu_err  = misal;
   assign wr_ack   = cpu_stb && cpu_we && !rd_act && !misal && !wf_full;
   assign rd_ack   = cpu_stb && !cpu_we && rd_act && !rf_empty;
   assign cpu_ack  = wr_ack || rd_ack;
   assign rd_start = cpu_stb && !cpu_we && start && !misal;
   assign rd_burst = cpu_burst;
   assign rd_addr  = cpu_burst ? {cpu_addr[31:4], 4'h0} : {cpu_addr[31:2], 2'b00};
   assign rf_pop   = rd_ack && word_end;
   assign par_err  = perr_q;

   always_comb begin
      merged  = wbuf;
      lane_be = '0;
      for (int i = 0; i < BYTES; i++) begin
         merged[8*(int'(boff)+i) +: 8] = cpu_wdata[8*i +: 8];
         lane_be[int'(boff)+i]         = 1'b1;
         cpu_rdata[8*i +: 8]           = rf_rdata[8*(int'(boff)+i) +: 8];
      end
   end

   if (PAR_EN) begin : g_par
      always_comb begin
         beat_bad = 1'b0;
         for (int i = 0; i < BYTES; i++) begin
            if (cpu_wpar[i] != odd_par8(cpu_wdata[8*i +: 8])) beat_bad = 1'b1;
            cpu_rpar[i] = odd_par8(cpu_rdata[8*i +: 8]);
         end
      end
   end else begin : g_nopar
      logic unused_wpar;
      assign unused_wpar = ^cpu_wpar;
      assign beat_bad    = 1'b0;
      assign cpu_rpar    = '0;
   end

   assign wf_push       = wr_ack && word_end && !bad_q && !beat_bad;
   assign wf_wdata.addr = burst_now ? {base_hi, bpos[3:2], 2'b00} : {cpu_addr[31:2], 2'b00};
   assign wf_wdata.data = merged;
   assign wf_wdata.be   = burst_now ? 4'hF : lane_be;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bc         <= '0;
         rd_act     <= 1'b0;
         rd_burst_q <= 1'b0;
         rd_off_q   <= '0;
         base_q     <= '0;
         wbuf       <= '0;
         bad_q      <= 1'b0;
         perr_q     <= 1'b0;
      end else begin
         if (rd_start) begin
            rd_act     <= 1'b1;
            rd_burst_q <= cpu_burst;
            rd_off_q   <= cpu_addr[1:0] & OFF_MAX;
         end
         if (cpu_ack && burst_now) bc <= (bc == 4'(NB-1)) ? '0 : bc + 1'b1;
         if (rd_ack && (!burst_now || bc == 4'(NB-1))) rd_act <= 1'b0;
         if (wr_ack) begin
            wbuf  <= merged;
            bad_q <= word_end ? 1'b0 : (bad_q || beat_bad);
            if (bc == '0) base_q <= cpu_addr[31:4];
         end
         if ((wr_ack && beat_bad) || sys_perr) perr_q <= 1'b1;
      end
   end

   AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |=> par_err);  // R5
   AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_act) |-> (bc == '0));  // R3

endmodule

// File: rtl/brg_sys_side.sv
module brg_sys_side
   import brg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wf_empty,
   input  wr_ent_t     wf_head,
   output logic        wf_pop,
   input  logic        rf_full,
   output logic        rf_push,
   input  logic        rd_start,
   input  logic        rd_burst,
   input  logic [31:0] rd_addr,
   output logic        sys_req,
   output logic        sys_we,
   output logic [31:0] sys_addr,
   output logic [3:0]  sys_be,
   output logic [31:0] sys_wdata,
   output logic        sys_wpar,
   input  logic        sys_gnt,
   input  logic        sys_rdy,
   input  logic [31:0] sys_rdata,
   input  logic        sys_rpar,
   output logic        sys_perr
);
   logic [2:0]  rd_left;
   logic [31:0] rd_ptr;
   logic        use_wr, rd_want, done;

   assign use_wr    = !wf_empty;
   assign rd_want   = (rd_left != '0) && !rf_full;
   assign sys_req   = use_wr || rd_want;
   assign sys_we    = use_wr;
   assign sys_addr  = use_wr ? wf_head.addr : rd_ptr;
   assign sys_be    = use_wr ? wf_head.be : 4'hF;
   assign sys_wdata = use_wr ? wf_head.data : '0;
   assign sys_wpar  = ~^sys_wdata;
   assign done      = sys_req && sys_gnt && sys_rdy;
   assign wf_pop    = done && use_wr;
   assign rf_push   = done && !use_wr;
   assign sys_perr  = rf_push && (sys_rpar != ~^sys_rdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_left <= '0;
         rd_ptr  <= '0;
      end else if (rd_start) begin
         rd_left <= rd_burst ? 3'd4 : 3'd1;
         rd_ptr  <= rd_addr;
      end else if (rf_push) begin
         rd_left <= rd_left - 1'b1;
         rd_ptr  <= rd_ptr + 32'd4;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_req && !(sys_gnt && sys_rdy)) |=> (sys_req && $stable(sys_addr) && $stable(sys_we)));  // R11

endmodule

// File: rtl/cpu_sys_bridge.sv
module cpu_sys_bridge
   import brg_pkg::*;
#(
   parameter int PW         = 16,
   parameter bit PAR_EN     = 1'b1,
   parameter int FIFO_DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_stb,
   input  logic            cpu_we,
   input  logic            cpu_burst,
   input  logic [31:0]     cpu_addr,
   input  logic [PW-1:0]   cpu_wdata,
   input  logic [PW/8-1:0] cpu_wpar,
   output logic            cpu_ack,
   output logic            cpu_err,
   output logic [PW-1:0]   cpu_rdata,
   output logic [PW/8-1:0] cpu_rpar,
   output logic            par_err,
   output logic            sys_req,
   output logic            sys_we,
   output logic [31:0]     sys_addr,
   output logic [3:0]      sys_be,
   output logic [31:0]     sys_wdata,
   output logic            sys_wpar,
   input  logic            sys_gnt,
   input  logic            sys_rdy,
   input  logic [31:0]     sys_rdata,
   input  logic            sys_rpar
);
   localparam int WENT_W = $bits(wr_ent_t);

   if (!(PW == 8 || PW == 16 || PW == 32)) begin : g_bad_pw
      $error("cpu_sys_bridge: PW must be 8, 16 or 32");
   end
   if (FIFO_DEPTH < 4) begin : g_small_fifo
      $error("cpu_sys_bridge: FIFO_DEPTH must hold a whole burst (4 words)");
   end

   logic        wf_push, wf_pop, wf_empty, wf_full;
   logic        rf_push, rf_pop, rf_empty, rf_full;
   wr_ent_t     wf_in, wf_head;
   logic [31:0] rf_head;
   logic        rd_start, rd_burst, sys_perr;
   logic [31:0] rd_addr;

   brg_cpu_side #(.PW(PW), .PAR_EN(PAR_EN)) cpu_i (
      .clk, .rst_n, .cpu_stb, .cpu_we, .cpu_burst, .cpu_addr, .cpu_wdata, .cpu_wpar,
      .cpu_ack, .cpu_err, .cpu_rdata, .cpu_rpar, .par_err, .sys_perr,
      .wf_push, .wf_wdata(wf_in), .wf_full, .rf_pop, .rf_rdata(rf_head), .rf_empty,
      .rd_start, .rd_burst, .rd_addr
   );

   brg_fifo #(.W(WENT_W), .DEPTH(FIFO_DEPTH)) wfifo_i (
      .clk, .rst_n, .push(wf_push), .wdata(wf_in), .pop(wf_pop),
      .rdata(wf_head), .empty(wf_empty), .full(wf_full)
   );

   brg_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) rfifo_i (
      .clk, .rst_n, .push(rf_push), .wdata(sys_rdata), .pop(rf_pop),
      .rdata(rf_head), .empty(rf_empty), .full(rf_full)
   );

   brg_sys_side sys_i (
      .clk, .rst_n, .wf_empty, .wf_head, .wf_pop, .rf_full, .rf_push,
      .rd_start, .rd_burst, .rd_addr,
      .sys_req, .sys_we, .sys_addr, .sys_be, .sys_wdata, .sys_wpar,
      .sys_gnt, .sys_rdy, .sys_rdata, .sys_rpar, .sys_perr
   );

endmodule

// File: tb/cpu_sys_bridge_tb.sv
module cpu_sys_bridge_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        cpu_stb = 0, cpu_we = 0, cpu_burst = 0;
   logic [31:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [1:0]  cpu_wpar = '0;
   logic        cpu_ack, cpu_err, par_err;
   logic [15:0] cpu_rdata;
   logic [1:0]  cpu_rpar;
   logic        sys_req, sys_we, sys_wpar;
   logic [31:0] sys_addr, sys_wdata, sys_rdata;
   logic [3:0]  sys_be;
   logic        sys_gnt = 1, sys_rdy = 1, sys_rpar, corrupt = 0;

   logic [31:0] mem [16];
   logic [31:0] alog [64];
   int n_chk = 0, n_err = 0, n_xfer = 0;

   assign sys_rdata = mem[sys_addr[5:2]];
   assign sys_rpar  = (~^sys_rdata) ^ corrupt;

   cpu_sys_bridge dut_i (
      .clk, .rst_n, .cpu_stb, .cpu_we, .cpu_burst, .cpu_addr, .cpu_wdata, .cpu_wpar,
      .cpu_ack, .cpu_err, .cpu_rdata, .cpu_rpar, .par_err,
      .sys_req, .sys_we, .sys_addr, .sys_be, .sys_wdata, .sys_wpar,
      .sys_gnt, .sys_rdy, .sys_rdata, .sys_rpar
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // slave model: transfer seen mid-cycle, completes at the next rising edge
   always @(negedge clk) begin
      #1;
      if (rst_n && sys_req && sys_gnt && sys_rdy) begin
         alog[n_xfer % 64] = sys_addr;
         n_xfer++;
         if (sys_we) begin
            chk(sys_wpar == ~^sys_wdata, "R7 sys_wpar", {31'b0, sys_wpar}, {31'b0, ~^sys_wdata});
            for (int b = 0; b < 4; b++)
               if (sys_be[b]) mem[sys_addr[5:2]][8*b +: 8] = sys_wdata[8*b +: 8];
         end
      end
   end

   task automatic beat(input logic we, input logic bst, input logic [31:0] a, input logic [15:0] d,
                       input logic badp, output logic [15:0] rd, output logic er, output logic ak);
      int w = 0;
      @(negedge clk);
      cpu_stb = 1; cpu_we = we; cpu_burst = bst; cpu_addr = a; cpu_wdata = d;
      cpu_wpar = {~^d[15:8], ~^d[7:0]} ^ {1'b0, badp};
      #1;
      while (!cpu_ack && !cpu_err && w < 300) begin
         @(negedge clk); #1; w++;
      end
      rd = cpu_rdata; er = cpu_err; ak = cpu_ack;
      if (w >= 300) chk(0, "beat timeout", 0, 1);
      if (!we && cpu_ack)
         chk(cpu_rpar == {~^rd[15:8], ~^rd[7:0]}, "R6 cpu_rpar", {30'b0, cpu_rpar}, {30'b0, ~^rd[15:8], ~^rd[7:0]});
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      cpu_stb = 0; cpu_burst = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   // {we, addr[7:0], data}; for reads the data is the expected value
   localparam logic [24:0] VEC [0:9] = '{
      25'h1201234, 25'h122abcd, 25'h0201234, 25'h022abcd, 25'h1265a5a,
      25'h0265a5a, 25'h1220f0f, 25'h0201234, 25'h0220f0f, 25'h0265a5a
   };

   function automatic logic [15:0] bd(input int k);
      return 16'h1000 + 16'(k) * 16'h0101;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      logic er, ak;
      int x0;
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(!cpu_ack && !cpu_err, "R10 ack/err after reset", {30'b0, cpu_ack, cpu_err}, 0);
      chk(!sys_req, "R10 sys_req after reset", {31'b0, sys_req}, 0);
      chk(!par_err, "R10 par_err after reset", {31'b0, par_err}, 0);

      // vector walk: single beats, R1
      for (int v = 0; v < 10; v++) begin
         beat(VEC[v][24], 1'b0, {24'b0, VEC[v][23:16]}, VEC[v][15:0], 1'b0, rd, er, ak);
         idle();
         if (!VEC[v][24]) chk(rd == VEC[v][15:0], "R1 single read", {16'b0, rd}, {16'b0, VEC[v][15:0]});
      end
      repeat (4) @(negedge clk);
      chk(mem[8] == 32'h0f0f1234, "R1 lane packing", mem[8], 32'h0f0f1234);
      chk(mem[9] == 32'h5a5a0000, "R1 byte enables", mem[9], 32'h5a5a0000);

      // burst write at 0x10, R2
      x0 = n_xfer;
      for (int k = 0; k < 8; k++) beat(1'b1, 1'b1, 32'h10, bd(k), 1'b0, rd, er, ak);
      idle();
      repeat (6) @(negedge clk);
      chk(n_xfer - x0 == 4, "R2 burst word count", n_xfer - x0, 4);
      for (int j = 0; j < 4; j++) begin
         chk(alog[(x0 + j) % 64] == 32'h10 + 4*j, "R2 burst address", alog[(x0 + j) % 64], 32'h10 + 4*j);
         chk(mem[4 + j] == {bd(2*j+1), bd(2*j)}, "R2 burst packing", mem[4 + j], {bd(2*j+1), bd(2*j)});
      end

      // burst read, R3
      x0 = n_xfer;
      for (int k = 0; k < 8; k++) begin
         beat(1'b0, 1'b1, 32'h10, 16'h0, 1'b0, rd, er, ak);
         chk(rd == bd(k), "R3 burst read beat", {16'b0, rd}, {16'b0, bd(k)});
      end
      idle();
      chk(n_xfer - x0 == 4, "R3 burst read words", n_xfer - x0, 4);

      // misaligned bursts, R4
      x0 = n_xfer;
      beat(1'b1, 1'b1, 32'h32, 16'h9999, 1'b0, rd, er, ak);
      chk(er && !ak, "R4 misaligned write", {30'b0, er, ak}, 32'h2);
      idle();
      beat(1'b0, 1'b1, 32'h14, 16'h0, 1'b0, rd, er, ak);
      chk(er && !ak, "R4 misaligned read", {30'b0, er, ak}, 32'h2);
      idle();
      repeat (5) @(negedge clk);
      chk(n_xfer == x0, "R4 no transfer", n_xfer - x0, 0);

      // write queue full, R8 / R11
      sys_rdy = 0;
      for (int k = 0; k < 4; k++) begin
         beat(1'b1, 1'b0, 32'(2*k), 16'h1111 * 16'(k+1), 1'b0, rd, er, ak);
         idle();
      end
      @(negedge clk);
      cpu_stb = 1; cpu_we = 1; cpu_addr = 32'h08; cpu_wdata = 16'h5555; cpu_wpar = 2'b11;
      #1; chk(!cpu_ack, "R8 ack held while full", {31'b0, cpu_ack}, 0);
      repeat (3) @(negedge clk);
      #1; chk(!cpu_ack, "R8 ack still held", {31'b0, cpu_ack}, 0);
      chk(sys_req && sys_addr == 32'h0, "R11 request held", sys_addr, 0);
      sys_rdy = 1;
      beat(1'b1, 1'b0, 32'h08, 16'h5555, 1'b0, rd, er, ak);
      idle();
      repeat (8) @(negedge clk);
      chk(mem[0] == 32'h22221111, "R8 queued words kept", mem[0], 32'h22221111);

      // read held until data, R8
      sys_rdy = 0;
      @(negedge clk);
      cpu_stb = 1; cpu_we = 0; cpu_burst = 0; cpu_addr = 32'h08;
      repeat (4) @(negedge clk);
      #1; chk(!cpu_ack, "R8 read ack held", {31'b0, cpu_ack}, 0);
      sys_rdy = 1;
      beat(1'b0, 1'b0, 32'h08, 16'h0, 1'b0, rd, er, ak);
      idle();
      chk(rd == 16'h5555, "R8 read after stall", {16'b0, rd}, 32'h5555);

      // write then read same address with stalled bus, R9
      sys_rdy = 0;
      beat(1'b1, 1'b0, 32'h24, 16'hbeef, 1'b0, rd, er, ak);
      idle();
      @(negedge clk);
      cpu_stb = 1; cpu_we = 0; cpu_addr = 32'h24;
      repeat (3) @(negedge clk);
      sys_rdy = 1;
      beat(1'b0, 1'b0, 32'h24, 16'h0, 1'b0, rd, er, ak);
      idle();
      chk(rd == 16'hbeef, "R9 read sees earlier write", {16'b0, rd}, 32'hbeef);

      // bad write parity, R5
      chk(!par_err, "R5 flag clear before", {31'b0, par_err}, 0);
      beat(1'b1, 1'b0, 32'h08, 16'h7777, 1'b1, rd, er, ak);
      idle();
      repeat (6) @(negedge clk);
      chk(par_err, "R5 flag set", {31'b0, par_err}, 1);
      chk(mem[2][15:0] == 16'h5555, "R5 bad word dropped", mem[2], 32'h5555);
      repeat (4) @(negedge clk);
      chk(par_err, "R5 flag sticky", {31'b0, par_err}, 1);

      // internal read parity, R7
      do_reset();
      #1; chk(!par_err, "R10 flag cleared by reset", {31'b0, par_err}, 0);
      corrupt = 1;
      beat(1'b0, 1'b0, 32'h20, 16'h0, 1'b0, rd, er, ak);
      idle();
      corrupt = 0;
      #1;
      chk(par_err, "R7 read parity flagged", {31'b0, par_err}, 1);
      chk(rd == 16'h1234, "R7 data still delivered", {16'b0, rd}, 32'h1234);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule